// File: doc/BRIEF.md
# Reset Strap Capture and Pin Repurposing

This block reads a set of configuration pins once, when the chip leaves reset, and keeps what it read as configuration bits for the rest of the session. Once those values are held, some of the same pins are reused. Two of them become driven status outputs. Two others are held actively low. The pad circuits and the serial bus engines that use these bits are outside this block.

The raw reset is asserted asynchronously, and its release passes through a synchronizer. The strap pins pass through their own synchronizer. The capture happens on the first clock edge after the synchronized release. With two stages, that is the third rising edge after the raw reset goes high. While reset is held, and until the capture, every pin the block controls is tri-stated so that board pull resistors set the levels.

Top module: `strap_capture`

## Requirements
- R1: The configuration outputs read 0 until the capture. The capture happens on the third rising clock edge after `rst_n` rises, and it takes the pin levels present before that edge.
- R2: `cfg_chg_en_o[i]` is 1 exactly when `chg_strap_i[i]` was captured as 1, meaning charging is supported on port i.
- R3: `cfg_i2c_mode_o` is 1 when `bus_strap_i` was captured as 1, which selects I2C EEPROM master mode. It is 0 when the strap was 0, which selects SMBus slave mode.
- R4: From the edge after the capture, `bus_pin_oe_o` and `pmgmt_pin_oe_o` are 1, and `bus_pin_do_o` and `pmgmt_pin_do_o` are 0.
- R5: `auto_strap_i` is active low. When it is captured as 0, `cfg_auto_en_o` is 1. `cfg_cdp_en_o` equals `cfg_chg_en_o`, except that bit 0 is forced to 0 while automatic mode is on.
- R6: When SMBus mode is selected, `cfg_smb_a1_o` equals the captured `pmgmt_strap_i` and `cfg_smb_a2_o` equals the captured `gang_strap_i`. In I2C mode both are 0.
- R7: After the capture, the registered output on the next edge depends on `status_en_i`. When it is 1, `gang_pin_oe_o` is 1 and `gang_pin_do_o` follows `hs_link_up_i`. When it is 0, `gang_pin_oe_o` is 0.
- R8: After the capture, the registered output on the next edge depends on `status_en_i`. When it is 1, `auto_pin_oe_o` is 1 and `auto_pin_do_o` follows `hs_suspend_i`. When it is 0, `auto_pin_oe_o` is 0.
- R9: While reset is held, and until the edge after the capture, all four output enables are 0.
- R10: Captured values do not change when the strap pins change, until reset is asserted again.
- R11: `cfg_pwr_switch_o` is 1 when `pmgmt_strap_i` was captured as 0, meaning power switching and overcurrent inputs are supported. `cfg_ganged_o` is the captured gang strap. `cfg_pol_high_o` is the captured polarity strap, where 1 means active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Raw active-low reset, asynchronous assert |
| chg_strap_i | input | NPORT | Per-port charging-enable strap pins |
| auto_strap_i | input | 1 | Automatic charging strap, active low |
| bus_strap_i | input | 1 | Serial bus mode strap |
| pmgmt_strap_i | input | 1 | Power-management strap, 0 = switching supported |
| gang_strap_i | input | 1 | Ganged power control strap |
| pol_strap_i | input | 1 | Power control polarity strap |
| hs_link_up_i | input | 1 | Upstream link is connected at high speed |
| hs_suspend_i | input | 1 | Upstream high-speed link is suspended |
| status_en_i | input | 1 | Enables status output on repurposed pins |
| cfg_chg_en_o | output | NPORT | Charging supported per port |
| cfg_cdp_en_o | output | NPORT | Charging-downstream handshake allowed per port |
| cfg_auto_en_o | output | 1 | Automatic charging mode on |
| cfg_i2c_mode_o | output | 1 | 1 = I2C master, 0 = SMBus slave |
| cfg_pwr_switch_o | output | 1 | Power switching supported |
| cfg_ganged_o | output | 1 | Ganged power control |
| cfg_pol_high_o | output | 1 | Power control active high |
| cfg_smb_a1_o | output | 1 | SMBus address bit 1 |
| cfg_smb_a2_o | output | 1 | SMBus address bit 2 |
| bus_pin_oe_o | output | 1 | Bus-mode pin output enable |
| bus_pin_do_o | output | 1 | Bus-mode pin output value |
| pmgmt_pin_oe_o | output | 1 | Power-management pin output enable |
| pmgmt_pin_do_o | output | 1 | Power-management pin output value |
| gang_pin_oe_o | output | 1 | Gang pin output enable |
| gang_pin_do_o | output | 1 | Gang pin output value |
| auto_pin_oe_o | output | 1 | Auto pin output enable |
| auto_pin_do_o | output | 1 | Auto pin output value |

## Verification
Several properties are checked on every cycle:
- Captured values stay stable once taken.
- The capture is never earlier than the synchronized release.
- The pins stay tri-stated before the capture and are driven low after it.
- Port 0 loses the handshake under automatic mode.
- The SMBus address bits match the power straps.
- The status pins mirror their inputs one cycle late.

The exact capture edge, and the correct decoding of each of the 512 strap combinations, can only be shown by the bench's scenarios. The same holds for the retention of values after the pins are flipped, and for the full status sweep.

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NPORT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] chg_strap_i,
  input  logic             auto_strap_i,
  input  logic             bus_strap_i,
  input  logic             pmgmt_strap_i,
  input  logic             gang_strap_i,
  input  logic             pol_strap_i,
  input  logic             hs_link_up_i,
  input  logic             hs_suspend_i,
  input  logic             status_en_i,
  output logic [NPORT-1:0] cfg_chg_en_o,
  output logic [NPORT-1:0] cfg_cdp_en_o,
  output logic             cfg_auto_en_o,
  output logic             cfg_i2c_mode_o,
  output logic             cfg_pwr_switch_o,
  output logic             cfg_ganged_o,
  output logic             cfg_pol_high_o,
  output logic             cfg_smb_a1_o,
  output logic             cfg_smb_a2_o,
  output logic             bus_pin_oe_o,
  output logic             bus_pin_do_o,
  output logic             pmgmt_pin_oe_o,
  output logic             pmgmt_pin_do_o,
  output logic             gang_pin_oe_o,
  output logic             gang_pin_do_o,
  output logic             auto_pin_oe_o,
  output logic             auto_pin_do_o
);

  localparam int NSTRAP  = NPORT + 5;
  localparam int B_AUTO  = NPORT;
  localparam int B_BUS   = NPORT + 1;
  localparam int B_PMGMT = NPORT + 2;
  localparam int B_GANG  = NPORT + 3;
  localparam int B_POL   = NPORT + 4;
  localparam int LAST    = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0]             rst_pipe;
  logic [SYNC_STAGES-1:0][NSTRAP-1:0] pin_sync;
  logic [NSTRAP-1:0]                  cap;
  logic                               done;
  logic                               live;
  logic [NSTRAP-1:0]                  raw_pins;

  assign live     = rst_pipe[LAST];
  assign raw_pins = {pol_strap_i, gang_strap_i, pmgmt_strap_i, bus_strap_i,
                     auto_strap_i, chg_strap_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= '0;
    end else begin
      pin_sync[0] <= raw_pins;
      for (int i = 1; i < SYNC_STAGES; i++) pin_sync[i] <= pin_sync[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      done <= 1'b0;
    end else if (live && !done) begin
      cap  <= pin_sync[LAST];
      done <= 1'b1;
    end
  end

  assign cfg_chg_en_o     = cap[NPORT-1:0];
  assign cfg_auto_en_o    = done & ~cap[B_AUTO];
  assign cfg_cdp_en_o     = cap[NPORT-1:0] & ~{{(NPORT-1){1'b0}}, cfg_auto_en_o};
  assign cfg_i2c_mode_o   = cap[B_BUS];
  assign cfg_pwr_switch_o = done & ~cap[B_PMGMT];
  assign cfg_ganged_o     = cap[B_GANG];
  assign cfg_pol_high_o   = cap[B_POL];
  assign cfg_smb_a1_o     = done & ~cap[B_BUS] & cap[B_PMGMT];
  assign cfg_smb_a2_o     = done & ~cap[B_BUS] & cap[B_GANG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_pin_oe_o   <= 1'b0;
      pmgmt_pin_oe_o <= 1'b0;
      gang_pin_oe_o  <= 1'b0;
      gang_pin_do_o  <= 1'b0;
      auto_pin_oe_o  <= 1'b0;
      auto_pin_do_o  <= 1'b0;
    end else begin
      bus_pin_oe_o   <= done;
      pmgmt_pin_oe_o <= done;
      gang_pin_oe_o  <= done & status_en_i;
      gang_pin_do_o  <= done & status_en_i & hs_link_up_i;
      auto_pin_oe_o  <= done & status_en_i;
      auto_pin_do_o  <= done & status_en_i & hs_suspend_i;
    end
  end

  assign bus_pin_do_o   = 1'b0;
  assign pmgmt_pin_do_o = 1'b0;

  assert_capture_after_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(live));

  assert_hold_values_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> $stable(cap));

  assert_tristate_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> !(bus_pin_oe_o | pmgmt_pin_oe_o | gang_pin_oe_o | auto_pin_oe_o));

  assert_drive_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> (bus_pin_oe_o && pmgmt_pin_oe_o && !bus_pin_do_o && !pmgmt_pin_do_o));

  assert_auto_blocks_port0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto_en_o |-> !cfg_cdp_en_o[0]);

  assert_smb_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_i2c_mode_o) |-> (cfg_smb_a1_o == !cfg_pwr_switch_o && cfg_smb_a2_o == cfg_ganged_o));

  assert_gang_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done && status_en_i) |-> (gang_pin_oe_o && gang_pin_do_o == $past(hs_link_up_i)));

  assert_auto_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done && status_en_i) |-> (auto_pin_oe_o && auto_pin_do_o == $past(hs_suspend_i)));

endmodule

// File: tb/tb_strap_capture.sv
`timescale 1ns/1ps
module tb_strap_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] chg = '0;
  logic auto_s = 1'b1, bus_s = 1'b1, pm_s = 1'b0, gang_s = 1'b0, pol_s = 1'b1;
  logic hs_up = 1'b0, hs_susp = 1'b0, st_en = 1'b0;
  logic [3:0] chg_en, cdp_en;
  logic auto_en, i2c, pwsw, gng, polh, a1, a2;
  logic boe, bdo, poe, pdo, goe, gdo, aoe, ado;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strap_capture #(.NPORT(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .chg_strap_i(chg), .auto_strap_i(auto_s),
    .bus_strap_i(bus_s), .pmgmt_strap_i(pm_s), .gang_strap_i(gang_s), .pol_strap_i(pol_s),
    .hs_link_up_i(hs_up), .hs_suspend_i(hs_susp), .status_en_i(st_en),
    .cfg_chg_en_o(chg_en), .cfg_cdp_en_o(cdp_en), .cfg_auto_en_o(auto_en),
    .cfg_i2c_mode_o(i2c), .cfg_pwr_switch_o(pwsw), .cfg_ganged_o(gng),
    .cfg_pol_high_o(polh), .cfg_smb_a1_o(a1), .cfg_smb_a2_o(a2),
    .bus_pin_oe_o(boe), .bus_pin_do_o(bdo), .pmgmt_pin_oe_o(poe), .pmgmt_pin_do_o(pdo),
    .gang_pin_oe_o(goe), .gang_pin_do_o(gdo), .auto_pin_oe_o(aoe), .auto_pin_do_o(ado));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] cfg_vec();
    return {chg_en, cdp_en, auto_en, i2c, pwsw, gng, polh, a1, a2};
  endfunction

  task automatic run_combo(int c);
    logic [14:0] held;
    logic e_auto;
    @(negedge clk);
    rst_n = 1'b0;
    {pol_s, gang_s, pm_s, bus_s, auto_s, chg} = c[8:0];
    repeat (2) @(negedge clk);
    chk("R9", {boe, poe, goe, aoe}, 4'b0);
    chk("R1", cfg_vec(), 15'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", cfg_vec(), 15'd0);
    @(negedge clk);
    e_auto = ~c[4];
    chk("R2", chg_en, c[3:0]);
    chk("R5", {auto_en, cdp_en}, {e_auto, c[3:1], c[0] & ~e_auto});
    chk("R3", i2c, c[5]);
    chk("R11", {pwsw, gng, polh}, {~c[6], c[7], c[8]});
    chk("R6", {a1, a2}, c[5] ? 2'b00 : {c[6], c[7]});
    chk("R9", {boe, poe, goe, aoe}, 4'b0);
    @(negedge clk);
    chk("R4", {boe, bdo, poe, pdo}, 4'b1010);
    held = cfg_vec();
    {pol_s, gang_s, pm_s, bus_s, auto_s, chg} = ~c[8:0];
    repeat (4) @(negedge clk);
    chk("R10", cfg_vec(), held);
    if (c % 37 == 0) begin
      for (int s = 0; s < 8; s++) begin
        {st_en, hs_up, hs_susp} = s[2:0];
        @(negedge clk);
        chk("R7", {goe, gdo}, s[2] ? {1'b1, s[1]} : {1'b0, 1'b0});
        chk("R8", {aoe, ado}, s[2] ? {1'b1, s[0]} : {1'b0, 1'b0});
      end
      st_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {boe, poe, goe, aoe}, 4'b0);
    for (int c = 0; c < 512; c++) run_combo(c);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule